// File: doc/BRIEF.md
# Linear Burst Read Sequencer

This block is the device-side engine that serves synchronous burst reads from a banked memory. The host holds chip enable low and pulses the address-valid strobe low while it presents a start address. The address present on the last rising clock edge of that strobe-low window is captured. After a programmable initial latency, the sequencer streams one word per clock from an internal address counter, and that counter advances on every delivered word.

A ready output tells the host when the data output carries a word. Ready is low during the initial latency. It is also low during the extra wait cycles that are inserted the first time the burst crosses a 16-word aligned boundary. The counter wraps from the top of the address space to zero and the stream carries on. When the bank addressed at the start of the burst is busy programming or erasing, every word delivered is the status word instead of array content. The array is a plain synchronous RAM with a load port for filling it.

A burst runs until chip enable goes high, reset is asserted, or a new address is strobed in. A configuration write during a burst leaves the running burst untouched, because latency, wait setting and bank state are all captured when the address is latched.

Top module: `burst_rd_seq`

## Requirements
- R1: A burst starts only if the configuration mode field `cfg_mode` held 2'b01 (bit 1 low, bit 0 high) at the capture edge. For any other value, `dout_valid` stays 0 and `rdy` stays 1.
- R2: Every rising edge with `ce_n` and `adv_n` both low captures `addr_in` and restarts the sequence, so the last such edge defines the start address.
- R3: Let L = `cfg_lat` + 2, giving 2 to 17. The first word is presented in the cycle after the L-th rising edge that follows the capture edge. `rdy` and `dout_valid` are 0 before that word.
- R4: After the first word, one word is presented per clock from successive addresses, and `dout_valid` high always comes with `rdy` high.
- R5: On the first crossing into a 16-word aligned block after the start word, the sequencer inserts max(0, min(13, `cfg_ws` − (start mod 16))) idle cycles. The `cfg_ws` value used is the one held at the capture edge. Later crossings in the same burst insert none.
- R6: During inserted boundary cycles, `rdy` and `dout_valid` are both 0. Both return to 1 together with the next word.
- R7: After address 2^AW−1 the next word comes from address 0 and the burst continues.
- R8: A high `ce_n` ends the burst: `dout_valid` is 0 from the next cycle on and the burst does not resume when `ce_n` returns low. A configuration write during a burst does not end or alter it.
- R9: If `bank_busy` is set at the capture edge for the bank selected by the top log2(NBANK) address bits, every presented word equals `status_word`. This holds even if that busy bit clears during the burst.
- R10: After reset, `rdy` is 1, `dout_valid` is 0 and the mode is non-burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr_in | input | AW | Start address presented with the strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Read mode field; 2'b01 selects burst |
| cfg_lat | input | 4 | Initial latency code (L = code + 2) |
| cfg_ws | input | 4 | Programmed wait-state setting |
| bank_busy | input | NBANK | Per-bank program/erase busy flags |
| status_word | input | DW | Status value presented for busy banks |
| mem_we | input | 1 | Array load write enable |
| mem_waddr | input | AW | Array load address |
| mem_wdata | input | DW | Array load data |
| dout | output | DW | Burst data word |
| dout_valid | output | 1 | Word on `dout` is valid this cycle |
| rdy | output | 1 | Ready; low during latency and boundary waits |

## Verification
The boundary-crossing wait and the wrap from the top address to zero can land on the same word, because address zero is itself 16-aligned. The bench provokes this by starting a burst four words below the top with the wait setting at its maximum. It then expects exactly three idle cycles, followed by the word at address zero. The bench also writes the configuration in the middle of a burst while words are streaming. It checks that neither the latency nor the wait count of the running burst changes, and that the output stays in step with the model.

// File: rtl/brs_pkg.sv
package brs_pkg;

  localparam int SEG_W     = 4;
  localparam int MAX_EXTRA = 13;
  localparam int LAT_W     = 4;
  localparam int WS_W      = 4;
  localparam int CNT_W     = LAT_W + 1;

  localparam logic [1:0] MODE_BURST = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAT,
    ST_DATA,
    ST_HOLD
  } brs_state_e;

  // Boundary wait for a burst: wait setting minus offset in segment, clamped.
  function automatic logic [WS_W-1:0] extra_wait(input logic [WS_W-1:0]  ws,
                                                 input logic [SEG_W-1:0] off);
    logic [WS_W:0] diff;
    if (ws <= off) return '0;
    diff = {1'b0, ws} - {1'b0, off};
    if (diff > (WS_W+1)'(MAX_EXTRA)) return WS_W'(MAX_EXTRA);
    return diff[WS_W-1:0];
  endfunction

endpackage

// File: rtl/brs_cfg.sv
module brs_cfg
  import brs_pkg::*;
#(
  parameter logic [LAT_W-1:0] LAT_RESET = 4'd7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [LAT_W-1:0] cfg_lat,
  input  logic [WS_W-1:0]  cfg_ws,
  output logic             sync_en,
  output logic [CNT_W-1:0] lat_clks,
  output logic [WS_W-1:0]  ws_q
);

  logic [1:0]       mode_q, mode_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic [WS_W-1:0]  ws_d;

  always_comb begin
    mode_d = mode_q;
    lat_d  = lat_q;
    ws_d   = ws_q;
    if (cfg_we) begin
      mode_d = cfg_mode;
      lat_d  = cfg_lat;
      ws_d   = cfg_ws;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      lat_q  <= LAT_RESET;
      ws_q   <= '0;
    end else begin
      mode_q <= mode_d;
      lat_q  <= lat_d;
      ws_q   <= ws_d;
    end
  end

  assign sync_en  = (mode_q == MODE_BURST);
  assign lat_clks = {1'b0, lat_q} + CNT_W'(2);

endmodule

// File: rtl/brs_bank.sv
module brs_bank #(
  parameter int AW    = 10,
  parameter int NBANK = 4
) (
  input  logic [AW-1:0]    addr,
  input  logic [NBANK-1:0] busy,
  output logic             hit
);

  localparam int BW = $clog2(NBANK);

  logic [NBANK-1:0] match;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign match[b] = (addr[AW-1 -: BW] == BW'(b)) && busy[b];
  end

  assign hit = |match;

endmodule

// File: rtl/brs_ram.sv
module brs_ram #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             adv_n,
  input  logic [AW-1:0]    addr_in,
  input  logic             sync_en,
  input  logic [CNT_W-1:0] lat_clks,
  input  logic [WS_W-1:0]  ws,
  input  logic             busy_hit,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic             valid,
  output logic             rdy,
  output logic             status_sel
);

  brs_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WS_W-1:0]  wcnt_q, wcnt_d;
  logic [WS_W-1:0]  extra_q, extra_d;
  logic             crossed_q, crossed_d;
  logic             stat_q, stat_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic             at_seg;

  assign at_seg = (addr_q[SEG_W-1:0] == '0);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    wcnt_d    = wcnt_q;
    extra_d   = extra_q;
    crossed_d = crossed_q;
    stat_d    = stat_q;
    addr_d    = addr_q;
    rd_en     = 1'b0;
    if (ce_n) begin
      st_d = ST_IDLE;
    end else if (!adv_n) begin
      addr_d    = addr_in;
      st_d      = sync_en ? ST_LAT : ST_IDLE;
      cnt_d     = lat_clks;
      extra_d   = extra_wait(ws, addr_in[SEG_W-1:0]);
      crossed_d = 1'b0;
      stat_d    = busy_hit;
    end else begin
      unique case (st_q)
        ST_LAT: begin
          if (cnt_q == CNT_W'(1)) begin
            rd_en  = 1'b1;
            addr_d = addr_q + 1'b1;
            st_d   = ST_DATA;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_DATA: begin
          if (at_seg && !crossed_q) begin
            crossed_d = 1'b1;
            if (extra_q != '0) begin
              st_d   = ST_HOLD;
              wcnt_d = extra_q;
            end else begin
              rd_en  = 1'b1;
              addr_d = addr_q + 1'b1;
            end
          end else begin
            rd_en  = 1'b1;
            addr_d = addr_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (wcnt_q == WS_W'(1)) begin
            rd_en  = 1'b1;
            addr_d = addr_q + 1'b1;
            st_d   = ST_DATA;
          end else begin
            wcnt_d = wcnt_q - 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      wcnt_q    <= '0;
      extra_q   <= '0;
      crossed_q <= 1'b0;
      stat_q    <= 1'b0;
      addr_q    <= '0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      wcnt_q    <= wcnt_d;
      extra_q   <= extra_d;
      crossed_q <= crossed_d;
      stat_q    <= stat_d;
      addr_q    <= addr_d;
    end
  end

  assign rd_addr    = addr_q;
  assign valid      = (st_q == ST_DATA);
  assign rdy        = !((st_q == ST_LAT) || (st_q == ST_HOLD));
  assign status_sel = stat_q;

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import brs_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DW    = 16,
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             adv_n,
  input  logic [AW-1:0]    addr_in,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [3:0]       cfg_lat,
  input  logic [3:0]       cfg_ws,
  input  logic [NBANK-1:0] bank_busy,
  input  logic [DW-1:0]    status_word,
  input  logic             mem_we,
  input  logic [AW-1:0]    mem_waddr,
  input  logic [DW-1:0]    mem_wdata,
  output logic [DW-1:0]    dout,
  output logic             dout_valid,
  output logic             rdy
);

  logic             sync_en;
  logic [CNT_W-1:0] lat_clks;
  logic [WS_W-1:0]  ws_q;
  logic             busy_hit;
  logic             rd_en;
  logic [AW-1:0]    rd_addr;
  logic             status_sel;
  logic [DW-1:0]    ram_q;

  brs_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_mode (cfg_mode),
    .cfg_lat  (cfg_lat),
    .cfg_ws   (cfg_ws),
    .sync_en  (sync_en),
    .lat_clks (lat_clks),
    .ws_q     (ws_q)
  );

  brs_bank #(.AW(AW), .NBANK(NBANK)) u_bank (
    .addr (addr_in),
    .busy (bank_busy),
    .hit  (busy_hit)
  );

  brs_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .adv_n      (adv_n),
    .addr_in    (addr_in),
    .sync_en    (sync_en),
    .lat_clks   (lat_clks),
    .ws         (ws_q),
    .busy_hit   (busy_hit),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .valid      (dout_valid),
    .rdy        (rdy),
    .status_sel (status_sel)
  );

  brs_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (ram_q)
  );

  assign dout = status_sel ? status_word : ram_q;

endmodule

// File: rtl/burst_rd_seq_chk.sv
module burst_rd_seq_chk #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          adv_n,
  input logic          sync_en,
  input logic [DW-1:0] dout,
  input logic          dout_valid,
  input logic          rdy,
  input logic [DW-1:0] status_word,
  input logic          status_sel,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr
);

  // R1: capture in non-burst mode leaves the sequencer ready and idle
  a_r1_async_stays_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_n && !ce_n && !sync_en) |=> (rdy && !dout_valid));

  // R2: a strobe edge always restarts, so no word follows it directly
  a_r2_strobe_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_n && !ce_n) |=> !dout_valid);

  // R4 / R7: back-to-back array reads step the address by one, modulo the space
  a_r4_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == AW'($past(rd_addr) + 1'b1)));

  // R6: a valid word is never shown while ready is low
  a_r6_valid_implies_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> rdy);

  // R8: chip enable high ends the burst on the next cycle
  a_r8_ce_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!dout_valid && rdy));

  // R9: busy bank bursts show the status word
  a_r9_status_out: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && status_sel) |-> (dout == status_word));

endmodule

bind burst_rd_seq burst_rd_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ce_n        (ce_n),
  .adv_n       (adv_n),
  .sync_en     (sync_en),
  .dout        (dout),
  .dout_valid  (dout_valid),
  .rdy         (rdy),
  .status_word (status_word),
  .status_sel  (status_sel),
  .rd_en       (rd_en),
  .rd_addr     (rd_addr)
);

// File: tb/burst_rd_seq_bench.sv
`timescale 1ns/1ps
module burst_rd_seq_bench;

  localparam int AW    = 10;
  localparam int DW    = 16;
  localparam int NBANK = 4;
  localparam int DEPTH = 1 << AW;

  logic             clk;
  logic             rst_n;
  logic             ce_n;
  logic             adv_n;
  logic [AW-1:0]    addr_in;
  logic             cfg_we;
  logic [1:0]       cfg_mode;
  logic [3:0]       cfg_lat;
  logic [3:0]       cfg_ws;
  logic [NBANK-1:0] bank_busy;
  logic [DW-1:0]    status_word;
  logic             mem_we;
  logic [AW-1:0]    mem_waddr;
  logic [DW-1:0]    mem_wdata;
  logic [DW-1:0]    dout;
  logic             dout_valid;
  logic             rdy;

  int checks = 0;
  int errors = 0;
  int cur_lat = 7;
  int cur_ws = 0;

  burst_rd_seq #(.AW(AW), .DW(DW), .NBANK(NBANK)) u_burst_rd_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .addr_in(addr_in),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_lat(cfg_lat), .cfg_ws(cfg_ws),
    .bank_busy(bank_busy), .status_word(status_word),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .dout(dout), .dout_valid(dout_valid), .rdy(rdy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 37 + 16'h1357);
  endfunction

  function automatic int model_extra(input int ws, input int start);
    int d;
    d = ws - (start % 16);
    if (d < 0) d = 0;
    if (d > 13) d = 13;
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] m, input int lat, input int ws);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = m; cfg_lat = 4'(lat); cfg_ws = 4'(ws);
    @(negedge clk);
    cfg_we = 1'b0;
    cur_lat = lat; cur_ws = ws;
  endtask

  task automatic issue(input int start);
    @(negedge clk);
    adv_n = 1'b0; addr_in = AW'(start);
    @(negedge clk);
    adv_n = 1'b1;
  endtask

  // Follows a burst already latched; sampling starts after the first edge past capture.
  task automatic follow(input int start, input int nwords, input bit stat,
                        input bit poke, input bit drop_busy, input string req);
    int l;
    int ex;
    bit crossed;
    l = cur_lat + 2;
    ex = model_extra(cur_ws, start);
    crossed = 1'b0;
    for (int k = 1; k < l; k++) begin
      tick();
      check(!dout_valid && !rdy, req, "latency cycle", {dout_valid, rdy}, 0);
    end
    for (int w = 0; w < nwords; w++) begin
      int a;
      logic [DW-1:0] e;
      a = (start + w) % DEPTH;
      if (w > 0 && (a % 16) == 0 && !crossed) begin
        crossed = 1'b1;
        for (int j = 0; j < ex; j++) begin
          tick();
          check(!dout_valid && !rdy, "R6", "boundary wait", {dout_valid, rdy}, 0);
        end
      end
      tick();
      e = stat ? status_word : pat(a);
      check(dout_valid && rdy, (w == 0) ? "R3" : req, "word valid", {dout_valid, rdy}, 3);
      check(dout == e, stat ? "R9" : req, "word data", dout, e);
      if (poke && w == 3) begin
        cfg_we = 1'b1; cfg_mode = 2'b10; cfg_lat = 4'd15; cfg_ws = 4'd15;
      end
      if (drop_busy && w == 2) bank_busy = '0;
    end
  endtask

  task automatic run_burst(input int start, input int nwords, input bit stat,
                           input bit poke, input bit drop_busy, input string req);
    issue(start);
    follow(start, nwords, stat, poke, drop_busy, req);
  endtask

  task automatic t_reset();
    check(rdy == 1'b1, "R10", "rdy after reset", rdy, 1);
    check(dout_valid == 1'b0, "R10", "valid after reset", dout_valid, 0);
  endtask

  task automatic t_async_default();
    issue(40);
    for (int k = 0; k < 25; k++) begin
      tick();
      check(!dout_valid && rdy, "R10", "default mode is non-burst", {dout_valid, rdy}, 1);
    end
    set_cfg(2'b11, 0, 0);
    issue(40);
    for (int k = 0; k < 10; k++) begin
      tick();
      check(!dout_valid && rdy, "R1", "mode 11 gives no burst", {dout_valid, rdy}, 1);
    end
  endtask

  task automatic t_basic();
    set_cfg(2'b01, 0, 0);
    run_burst(5, 40, 1'b0, 1'b0, 1'b0, "R4");
    set_cfg(2'b01, 9, 0);
    run_burst(130, 20, 1'b0, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_multi_edge();
    set_cfg(2'b01, 2, 0);
    @(negedge clk); adv_n = 1'b0; addr_in = AW'(300);
    @(negedge clk); addr_in = AW'(410);
    @(negedge clk); addr_in = AW'(77);
    @(negedge clk); adv_n = 1'b1;
    follow(77, 8, 1'b0, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_boundary();
    set_cfg(2'b01, 5, 9);
    run_burst(3, 40, 1'b0, 1'b0, 1'b0, "R5");
    set_cfg(2'b01, 1, 15);
    run_burst(512, 20, 1'b0, 1'b0, 1'b0, "R5");
    set_cfg(2'b01, 1, 2);
    run_burst(7, 20, 1'b0, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_wrap();
    set_cfg(2'b01, 0, 15);
    run_burst(DEPTH - 4, 10, 1'b0, 1'b0, 1'b0, "R7");
  endtask

  task automatic t_terminate();
    set_cfg(2'b01, 0, 0);
    run_burst(100, 5, 1'b0, 1'b0, 1'b0, "R8");
    ce_n = 1'b1;
    tick();
    check(!dout_valid && rdy, "R8", "ce high ends burst", {dout_valid, rdy}, 1);
    ce_n = 1'b0;
    for (int k = 0; k < 12; k++) begin
      tick();
      check(!dout_valid, "R8", "burst does not resume", dout_valid, 0);
    end
    set_cfg(2'b01, 3, 6);
    run_burst(250, 30, 1'b0, 1'b1, 1'b0, "R8");
    set_cfg(2'b01, 0, 0);
    run_burst(200, 6, 1'b0, 1'b0, 1'b0, "R2");
    run_burst(600, 6, 1'b0, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_status();
    set_cfg(2'b01, 1, 4);
    bank_busy = 4'b0100;
    run_burst(520, 24, 1'b1, 1'b0, 1'b1, "R9");
    bank_busy = 4'b0100;
    run_burst(10, 6, 1'b0, 1'b0, 1'b0, "R9");
    bank_busy = '0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b0; adv_n = 1'b1; addr_in = '0;
    cfg_we = 1'b0; cfg_mode = 2'b00; cfg_lat = 4'd0; cfg_ws = 4'd0;
    bank_busy = '0; status_word = 16'hC3E1;
    mem_we = 1'b0; mem_waddr = '0; mem_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      mem_we = 1'b1; mem_waddr = AW'(a); mem_wdata = pat(a);
    end
    @(negedge clk);
    mem_we = 1'b0;
    t_async_default();
    t_basic();
    t_multi_edge();
    t_boundary();
    t_wrap();
    t_terminate();
    t_status();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule